// File: doc/BRIEF.md
# Configurable SPI Serial Engine

A full-duplex serial shift engine that runs either as the clock-driving master or as a slave clocked from outside. A single mode input picks the role. One parallel word goes in with a start strobe, and one received word comes out with a done pulse. Words are 8 or 16 bits long and travel MSB first. The idle clock level, the clock edge on which output data changes, and the master's input sample point are all set by static control inputs.

In master mode the serial clock is derived from the system clock through two dividers in series. The primary divider takes 1, 4, 16 or 64, and the secondary divider takes 1 to 8. The clock and data-out pins each have an output-enable flag, and each pin can be handed back to general I/O. In slave mode the external clock, data-in and an optional active-low select pass through two-flop synchronisers before edges are detected. Raising the select in the middle of a word abandons that word.

Top module: `spi_engine`

## Requirements
- R1: After reset, done_o is 0, rx_data_o is 0 and busy_o is 0.
- R2: While no master transfer is running, sck_o equals cpol_i (1 = idle high, 0 = idle low).
- R3: In master mode each half-period of sck_o lasts P × S system clocks. P comes from pre_pri_i: 2'b11 gives 1, 2'b10 gives 4, 2'b01 gives 16, 2'b00 gives 64. S is 8 minus pre_sec_i.
- R4: When P × S equals 1, the half-period is clamped to 2 system clocks.
- R5: wide_i = 1 gives 16-bit words and wide_i = 0 gives 8-bit words. An 8-bit word uses tx_data_i[7:0] and returns zeros in rx_data_o[15:8]. Bits are sent and received MSB first.
- R6: With cke_i = 1, the MSB is on sdo_o from the start and data changes on active-to-idle clock edges, so the first master half-period is idle. With cke_i = 0, data changes on idle-to-active edges, so the first master half-period is active.
- R7: In master mode, bit j is driven for half-periods 2j and 2j+1. With smp_end_i = 0, sdi_i is sampled at the end of half-period 2j. With smp_end_i = 1, it is sampled at the end of half-period 2j+1.
- R8: done_o is high for exactly one cycle after the last bit is sampled. rx_data_o changes only in that cycle and then holds until the next word completes.
- R9: With master_i = 1 and sck_dis_i = 1, sck_oe_o is 0 and start_i does not begin a transfer.
- R10: With sdo_dis_i = 1, sdo_oe_o is 0, and the transfer and its received word are otherwise unaffected.
- R11: With master_i = 0, sck_oe_o is 0, the engine shifts on sck_i edges, and smp_end_i is treated as 0. Each bit is sampled on the edge opposite the one on which the output changes.
- R12: With ss_en_i = 1, ss_ni high blocks slave shifting, sets sdo_oe_o to 0, and aborts a partly received word, reloading the transmit word. With ss_en_i = 0, ss_ni is ignored.
- R13: A start_i pulse during a master transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master, 0 = slave |
| wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cpol_i | input | 1 | Idle clock level |
| cke_i | input | 1 | 1 = data changes active-to-idle, 0 = idle-to-active |
| smp_end_i | input | 1 | Master sample point: 1 = end of bit, 0 = middle |
| pre_pri_i | input | 2 | Primary divider code |
| pre_sec_i | input | 3 | Secondary divider code |
| sck_dis_i | input | 1 | Stop master clock and release sck pin |
| sdo_dis_i | input | 1 | Release data-out pin |
| ss_en_i | input | 1 | Use ss_ni in slave mode |
| tx_data_i | input | 16 | Word to transmit |
| start_i | input | 1 | Load word; in master mode also begin transfer |
| rx_data_o | output | 16 | Last received word |
| done_o | output | 1 | One-cycle word-complete pulse |
| busy_o | output | 1 | Transfer in progress |
| sck_o | output | 1 | Master serial clock |
| sck_oe_o | output | 1 | Output enable for sck_o |
| sck_i | input | 1 | Slave serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sdi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select, active low |

## Verification
In master mode the bench drives sdi_i with a different value in each half-period. A wrong sample point therefore returns the other of two distinct words, and an off-by-one half count returns a shifted word. It measures sck_o half-periods for several divider codes, including the forbidden 1:1 pair. A missing clamp shows up as a 1-cycle half-period and a wrong code table as a wrong length. In slave mode it acts as an external master in both edge modes, with smp_end_i held at 1. It also raises the select partway through a word: a design that keeps the partial bits delivers a corrupted word, and one that honours a disabled select stalls. Start pulses are issued during a transfer and with the clock disabled; a design that acts on them changes the transmitted bits or starts a transfer.

// File: rtl/spi_engine_pkg.sv
package spi_engine_pkg;
  // System clocks per sck half-period, clamped to at least 2
  function automatic int unsigned half_cycles(input logic [1:0] pri, input logic [2:0] sec);
    int unsigned p, s, h;
    p = 32'd1 << {~pri, 1'b0};
    s = 32'd8 - {29'd0, sec};
    h = p * s;
    if (h < 32'd2) h = 32'd2;
    return h;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end
  assign q_o = s2;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] pri_i,
  input  logic [2:0] sec_i,
  output logic       tick_o
);
  import spi_engine_pkg::*;
  logic [DIV_W-1:0] cnt, half_m1;

  always_comb half_m1 = DIV_W'(half_cycles(pri_i, sec_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt <= '0;
    else if (!en_i)           cnt <= '0;
    else if (cnt >= half_m1)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick_o = en_i && (cnt >= half_m1);

  // R4
  no_fast_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              started_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_data_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh, hold, rx;
  logic [CNT_W-1:0]  cnt, last_bit;

  assign last_bit = wide_i ? CNT_W'(WORD_W - 1) : CNT_W'(NARROW_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh <= '0; hold <= '0; rx <= '0; cnt <= '0;
      done_o <= 1'b0; rx_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        sh <= load_data_i; hold <= load_data_i; rx <= '0; cnt <= '0;
      end else if (clear_i) begin
        sh <= hold; rx <= '0; cnt <= '0;
      end else begin
        if (shift_i) sh <= {sh[WORD_W-2:0], 1'b0};
        if (sample_i) begin
          if (cnt == last_bit) begin
            cnt       <= '0;
            rx        <= '0;
            done_o    <= 1'b1;
            rx_data_o <= {rx[WORD_W-2:0], sdi_i};  // rx starts at zero, so upper bits stay 0 for narrow words
          end else begin
            cnt <= cnt + 1'b1;
            rx  <= {rx[WORD_W-2:0], sdi_i};
          end
        end
      end
    end
  end

  assign sdo_o     = wide_i ? sh[WORD_W-1] : sh[NARROW_W-1];
  assign started_o = (cnt != '0);

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> done_o);
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DIV_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              wide_i,
  input  logic              cpol_i,
  input  logic              cke_i,
  input  logic              smp_end_i,
  input  logic [1:0]        pre_pri_i,
  input  logic [2:0]        pre_sec_i,
  input  logic              sck_dis_i,
  input  logic              sdo_dis_i,
  input  logic              ss_en_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              start_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sck_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i,
  input  logic              ss_ni
);
  localparam int HALF_W = $clog2(2 * WORD_W);

  // master sequencing
  logic              m_busy, tick, m_start, last_half, smp_eff, m_sample, m_shift;
  logic [HALF_W-1:0] k;

  assign m_start   = master_i && start_i && !m_busy && !sck_dis_i;
  assign last_half = (k == (wide_i ? HALF_W'(2*WORD_W-1) : HALF_W'(2*NARROW_W-1)));
  assign smp_eff   = master_i & smp_end_i;
  assign m_sample  = tick && (k[0] == smp_eff);
  assign m_shift   = tick && k[0] && !last_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; k <= '0;
    end else if (!master_i) begin
      m_busy <= 1'b0; k <= '0;
    end else if (m_start) begin
      m_busy <= 1'b1; k <= '0;
    end else if (tick) begin
      if (last_half) m_busy <= 1'b0;
      else           k <= k + 1'b1;
    end
  end

  spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(m_busy),
    .pri_i(pre_pri_i), .sec_i(pre_sec_i), .tick_o(tick)
  );

  // slave front end
  logic sck_s, ss_s, sdi_s, sck_q, rise, fall, lead, trail, sel, s_sample, s_change, s_clear;

  spi_sync #(.W(3)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sck_i, ss_ni, sdi_i}), .q_o({sck_s, ss_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign rise     = sck_s & ~sck_q;
  assign fall     = ~sck_s & sck_q;
  assign lead     = cpol_i ? fall : rise;
  assign trail    = cpol_i ? rise : fall;
  assign sel      = !ss_en_i || !ss_s;
  assign s_sample = sel && (cke_i ? lead : trail);
  assign s_change = sel && (cke_i ? trail : lead);
  assign s_clear  = !master_i && ss_en_i && ss_s;

  // shared shift path
  logic started, sh_sdo;

  spi_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i),
    .load_i(master_i ? m_start : start_i), .load_data_i(tx_data_i),
    .clear_i(s_clear),
    .sample_i(master_i ? m_sample : s_sample),
    .shift_i(master_i ? m_shift : (s_change && started)),
    .sdi_i(master_i ? sdi_i : sdi_s),
    .sdo_o(sh_sdo), .started_o(started), .done_o(done_o), .rx_data_o(rx_data_o)
  );

  assign sck_o    = m_busy ? (cpol_i ^ k[0] ^ ~cke_i) : cpol_i;
  assign sck_oe_o = master_i && !sck_dis_i;
  assign sdo_o    = sh_sdo;
  assign sdo_oe_o = !sdo_dis_i && (master_i || sel);
  assign busy_o   = master_i ? m_busy : started;

  // R9
  sck_dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && sck_dis_i && !busy_o) |=> !busy_o);
  // R13
  busy_until_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_busy && !tick && master_i) |=> m_busy);
  // R10
  sdo_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_dis_i |-> !sdo_oe_o);
  // R11
  slave_sck_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sck_oe_o);
endmodule

// File: tb/spi_engine_bench.sv
module spi_engine_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic master = 1'b1, wide = 1'b0, cpol = 1'b0, cke = 1'b1, smp = 1'b0;
  logic [1:0] pri = 2'b10;
  logic [2:0] sec = 3'b111;
  logic sck_dis = 1'b0, sdo_dis = 1'b0, ss_en = 1'b0, start = 1'b0;
  logic [15:0] tx = '0;
  logic sck_drv = 1'b0, ss_drv = 1'b1, sdi_m = 1'b0, sdi_s = 1'b0, mdl_en = 1'b1;
  logic [15:0] rx_data_o;
  logic done_o, busy_o, sck_o, sck_oe_o, sdo_o, sdo_oe_o;
  wire sdi = mdl_en ? sdi_m : sdi_s;

  spi_engine u_spi_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master), .wide_i(wide), .cpol_i(cpol),
    .cke_i(cke), .smp_end_i(smp), .pre_pri_i(pri), .pre_sec_i(sec), .sck_dis_i(sck_dis),
    .sdo_dis_i(sdo_dis), .ss_en_i(ss_en), .tx_data_i(tx), .start_i(start),
    .rx_data_o(rx_data_o), .done_o(done_o), .busy_o(busy_o), .sck_o(sck_o),
    .sck_oe_o(sck_oe_o), .sck_i(sck_drv), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .sdi_i(sdi), .ss_ni(ss_drv)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // master-side bench model: counts sck toggles, drives sdi per half-period, captures sdo per bit
  int cyc = 0, tog = 0, t_t1 = 0, half_meas = 0, done_cnt = 0, wbits = 8;
  logic busy_q = 1'b0, sck_q = 1'b0, first_sck = 1'b0, oe_seen = 1'b0;
  logic [15:0] pa = '0, pb = '0, txcap = '0;
  always @(negedge clk_i) begin
    cyc++;
    if (done_o) done_cnt++;
    if (!busy_o || !master) tog = 0;
    else if (!busy_q) begin tog = 0; first_sck = sck_o; end
    else if (sck_o != sck_q) begin
      tog++;
      if (tog == 1) t_t1 = cyc;
      if (tog == 2) half_meas = cyc - t_t1;
    end
    if (master && busy_o) begin
      txcap[wbits-1-tog/2] = sdo_o;
      sdi_m = (tog % 2 == 0) ? pa[wbits-1-tog/2] : pb[wbits-1-tog/2];
      if (sdo_oe_o) oe_seen = 1'b1;
    end
    busy_q = busy_o;
    sck_q  = sck_o;
  end

  task automatic m_run(input logic [15:0] d, input logic [15:0] a, input logic [15:0] b,
                       input int exp_half, input int poke, input string tag);
    logic [15:0] mask, exp_rx;
    int n;
    wbits = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    pa = a; pb = b; mdl_en = 1'b1; done_cnt = 0; oe_seen = 1'b0; txcap = '0;
    exp_rx = (smp ? b : a) & mask;
    tx = d; start = 1'b1;
    @(negedge clk_i);
    start = 1'b0; tx = ~d;
    n = 0;
    while (busy_o && n < 20000) begin
      start = (n == poke && poke > 0);
      @(negedge clk_i);
      n++;
    end
    start = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(rx_data_o == exp_rx, {tag, " R5 R7 rx word"}, rx_data_o, exp_rx);
    chk(txcap == (d & mask), {tag, " R5 R6 sdo bits"}, txcap, d & mask);
    chk(first_sck == (cpol ^ ~cke), {tag, " R6 first half level"}, first_sck, cpol ^ ~cke);
    chk(half_meas == exp_half, {tag, " R3 R4 half period"}, half_meas, exp_half);
    chk(done_cnt == 1, {tag, " R8 R13 done count"}, done_cnt, 1);
    chk(sck_o == cpol, {tag, " R2 idle level"}, sck_o, cpol);
    repeat (20) @(negedge clk_i);
    chk(rx_data_o == exp_rx, {tag, " R8 rx held"}, rx_data_o, exp_rx);
  endtask

  // external-master model for slave tests
  task automatic s_bits(input logic [15:0] w, input int nb, input int nsend, output logic [15:0] got);
    got = '0;
    for (int j = 0; j < nsend; j++) begin
      if (cke) begin
        sdi_s = w[nb-1-j];
        repeat (8) @(negedge clk_i);
        got[nb-1-j] = sdo_o;
        sck_drv = ~cpol;
        repeat (8) @(negedge clk_i);
        sck_drv = cpol;
      end else begin
        sck_drv = ~cpol;
        sdi_s = w[nb-1-j];
        repeat (8) @(negedge clk_i);
        got[nb-1-j] = sdo_o;
        sck_drv = cpol;
        repeat (8) @(negedge clk_i);
      end
    end
    repeat (6) @(negedge clk_i);
  endtask

  task automatic s_setup(input logic [15:0] d);
    master = 1'b0; mdl_en = 1'b0; sck_drv = cpol;
    repeat (4) @(negedge clk_i);
    tx = d; start = 1'b1;
    @(negedge clk_i);
    start = 1'b0;
    done_cnt = 0;
  endtask

  task automatic t_reset;
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(rx_data_o == 16'h0, "R1 rx", rx_data_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(sck_o == cpol, "R2 reset idle", sck_o, cpol);
  endtask

  task automatic t_master_modes;
    master = 1'b1; wide = 1'b0; cpol = 1'b0; cke = 1'b1; smp = 1'b0; pri = 2'b10; sec = 3'b111;
    @(negedge clk_i);
    m_run(16'h003C, 16'h00A5, 16'h005A, 4, 0, "m8");
    wide = 1'b1; cpol = 1'b1; cke = 1'b0; smp = 1'b1; pri = 2'b11; sec = 3'b110;
    @(negedge clk_i);
    m_run(16'hC3A1, 16'h1234, 16'hBEEF, 2, 0, "m16");
  endtask

  task automatic t_dividers;
    wide = 1'b0; cpol = 1'b0; cke = 1'b1; smp = 1'b0; pri = 2'b11; sec = 3'b111;
    @(negedge clk_i);
    m_run(16'h0081, 16'h0066, 16'h0099, 2, 0, "clamp R4");
    pri = 2'b01; sec = 3'b101;
    @(negedge clk_i);
    m_run(16'h00E7, 16'h0018, 16'h00C3, 48, 0, "div48 R3");
    pri = 2'b00; sec = 3'b111;
    @(negedge clk_i);
    m_run(16'h0055, 16'h00F0, 16'h000F, 64, 0, "div64 R3");
  endtask

  task automatic t_pins;
    pri = 2'b10; sec = 3'b111; cke = 1'b0; smp = 1'b0;
    sck_dis = 1'b1; done_cnt = 0;
    @(negedge clk_i);
    chk(sck_oe_o == 1'b0, "R9 sck_oe", sck_oe_o, 0);
    tx = 16'h00AA; start = 1'b1;
    @(negedge clk_i);
    start = 1'b0;
    repeat (50) @(negedge clk_i);
    chk(busy_o == 1'b0 && done_cnt == 0, "R9 no transfer", {busy_o, 8'(done_cnt)}, 0);
    sck_dis = 1'b0; sdo_dis = 1'b1;
    @(negedge clk_i);
    m_run(16'h00D2, 16'h004B, 16'h00B4, 4, 0, "sdo_dis R10");
    chk(oe_seen == 1'b0, "R10 sdo_oe low", oe_seen, 0);
    sdo_dis = 1'b0;
    m_run(16'h0096, 16'h0033, 16'h00CC, 4, 9, "restart R13");
  endtask

  task automatic t_slave;
    logic [15:0] got;
    cpol = 1'b0; cke = 1'b1; smp = 1'b1; wide = 1'b0; ss_en = 1'b0;
    s_setup(16'h00C5);
    chk(sck_oe_o == 1'b0, "R11 sck_oe", sck_oe_o, 0);
    s_bits(16'h003A, 8, 8, got);
    chk(rx_data_o == 16'h003A && done_cnt == 1, "R11 slave cke1 rx", rx_data_o, 16'h003A);
    chk(got == 16'h00C5, "R11 slave cke1 sdo", got, 16'h00C5);
    cpol = 1'b1; cke = 1'b0; wide = 1'b1;
    s_setup(16'h9D2E);
    s_bits(16'h71B4, 16, 16, got);
    chk(rx_data_o == 16'h71B4 && done_cnt == 1, "R11 slave cke0 rx", rx_data_o, 16'h71B4);
    chk(got == 16'h9D2E, "R11 slave cke0 sdo", got, 16'h9D2E);
  endtask

  task automatic t_select;
    logic [15:0] got;
    cpol = 1'b0; cke = 1'b1; wide = 1'b0; ss_en = 1'b1; ss_drv = 1'b1;
    s_setup(16'h005C);
    chk(sdo_oe_o == 1'b0, "R12 sdo_oe deselected", sdo_oe_o, 0);
    s_bits(16'h00FF, 8, 8, got);
    chk(done_cnt == 0, "R12 blocked by ss", done_cnt, 0);
    ss_drv = 1'b0;
    repeat (4) @(negedge clk_i);
    s_bits(16'h0011, 8, 5, got);
    ss_drv = 1'b1;
    repeat (6) @(negedge clk_i);
    ss_drv = 1'b0;
    repeat (4) @(negedge clk_i);
    s_bits(16'h00A9, 8, 8, got);
    chk(rx_data_o == 16'h00A9 && done_cnt == 1, "R12 abort then word", rx_data_o, 16'h00A9);
    chk(got == 16'h005C, "R12 tx reloaded", got, 16'h005C);
    ss_en = 1'b0; ss_drv = 1'b1;
    s_setup(16'h0000);
    s_bits(16'h0047, 8, 8, got);
    chk(rx_data_o == 16'h0047 && done_cnt == 1, "R12 ss ignored", rx_data_o, 16'h0047);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_master_modes();
    t_dividers();
    t_pins();
    t_slave();
    t_select();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule